// File: doc/BRIEF.md
# JTAG Debug-Port Scan Register Target

This block is the target side of a debug port reached over a serial test-access link. It contains the 16-state test-access controller, a 4-bit instruction register and one shared shift chain. The loaded instruction picks which data register that chain stands in for: the one-bit bypass stage, the 32-bit identification word, the debug-port access register, the access-port access register, or the abort register.

Scans through the two access registers become requests on a simple internal port toward the debug-port and access-port register logic. The port holds a request until the back end acknowledges it. Access scans are pipelined. The 35 bits captured by any access scan carry the read data of the last completed request together with a 3-bit acknowledge. An access scan that begins while the port is still busy reports WAIT, and its own request is thrown away. A scan through the abort register can cancel a stuck request.

The host drives TCK, TMS, TDI and an active-low TRST. The block returns TDO and a TDO enable, and both change only on the falling TCK edge.

Top module: `jtag_dbg_scan`

## Requirements
- R1: TRST low resets the controller at once. Five consecutive rising TCK edges with TMS high reach Test-Logic-Reset from any state. In Test-Logic-Reset the instruction becomes 1110 (identification).
- R2: Capture-IR loads 0001 into the instruction shift stage. Shift-IR moves it toward TDO least significant bit first. The new instruction takes effect on Update-IR.
- R3: TDO and TDO enable change only on the falling TCK edge. TDO enable is high exactly while the controller is in Shift-IR or Shift-DR, and TDO is 0 whenever TDO enable is low.
- R4: With instruction 1110, Capture-DR loads the 32-bit word 0x3BA00477, which is shifted out least significant bit first.
- R5: Instruction 1111, and every code other than 1110, 1010, 1011 and 1000, selects a one-bit register that captures 0 and delays TDI by one TCK cycle.
- R6: Instructions 1010 (debug port) and 1011 (access port) select a 35-bit scan. The shifted-in bit 0 is the read flag (1 means read), bits [2:1] are the register address, and bits [34:3] are the write data. Update-DR raises acc_valid with these fields, and acc_ap is 1 for 1011.
- R7: On Capture-DR of an access scan while no request is outstanding, bits [2:0] are 010 (OK) and bits [34:3] are the read data of the last completed request.
- R8: acc_valid and its fields stay unchanged until acc_done is sampled high on a rising edge. acc_valid then drops, and acc_rdata is kept as the last read data.
- R9: If acc_valid is high at Capture-DR of an access scan, the capture holds 001 (WAIT) in bits [2:0] and zero in bits [34:3]. The request shifted in by that scan is discarded at Update-DR.
- R10: Instruction 1000 selects a 35-bit scan that captures zero. At Update-DR, if shifted-in bit 3 (abort flag) is 1, dp_abort pulses for one TCK cycle and acc_valid is cleared. If the flag is 0, the scan has no effect.
- R11: While TRST is low, acc_valid, dp_abort, TDO and TDO enable are 0, and the stored last read data is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| acc_valid | output | 1 | Internal request outstanding |
| acc_ap | output | 1 | Request targets the access port (else the debug port) |
| acc_addr | output | 2 | Register address of the request |
| acc_rnw | output | 1 | 1 for a read request, 0 for a write |
| acc_wdata | output | 32 | Write data of the request |
| acc_done | input | 1 | Back end completes the outstanding request |
| acc_rdata | input | 32 | Read data returned with acc_done |
| dp_abort | output | 1 | One-cycle abort pulse |

## Verification
The bench runs a request with no answer from the back end. It then starts a second access scan, which must report WAIT with zero data and leave the held request's fields untouched. A design that samples busy at Update-DR instead of Capture-DR, or that lets the new request overwrite the old one, shows up here as a wrong acknowledge or changed acc_addr and acc_wdata. Abort scans are sent with the flag clear and with it set. A design that decodes the wrong bit either drops a live request or fails to pulse dp_abort. The bench also samples TDO just after every rising edge, so a shift stage driven straight to TDO without the falling-edge register shows up as a mid-cycle change. After five TMS-high clocks and after TRST, an identification scan must return 0x3BA00477 and the next access scan must report zero read data.

// File: rtl/dbgscan_pkg.sv
package dbgscan_pkg;
   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
      ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
   } tap_state_e;

   typedef enum logic [2:0] {
      PICK_BYPASS, PICK_IDENT, PICK_DPORT, PICK_APORT, PICK_ABORT
   } dr_pick_e;

   localparam int unsigned INSN_W = 4;
   localparam logic [INSN_W-1:0] INSN_IDENT    = 4'b1110;
   localparam logic [INSN_W-1:0] INSN_DPORT    = 4'b1010;
   localparam logic [INSN_W-1:0] INSN_APORT    = 4'b1011;
   localparam logic [INSN_W-1:0] INSN_ABORT    = 4'b1000;
   localparam logic [INSN_W-1:0] INSN_CAPTURED = 4'b0001;
   localparam int unsigned IDENT_W = 32;
endpackage

// File: rtl/dbgscan_tap.sv
module dbgscan_tap
   import dbgscan_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);
   tap_state_e nxt;

   always_comb begin
      case (state)
         ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
         ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
         ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
         ST_DR_CAP:   nxt = tms ? ST_DR_EX1   : ST_DR_SHIFT;
         ST_DR_SHIFT: nxt = tms ? ST_DR_EX1   : ST_DR_SHIFT;
         ST_DR_EX1:   nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
         ST_DR_PAUSE: nxt = tms ? ST_DR_EX2   : ST_DR_PAUSE;
         ST_DR_EX2:   nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
         ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
         ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
         ST_IR_CAP:   nxt = tms ? ST_IR_EX1   : ST_IR_SHIFT;
         ST_IR_SHIFT: nxt = tms ? ST_IR_EX1   : ST_IR_SHIFT;
         ST_IR_EX1:   nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
         ST_IR_PAUSE: nxt = tms ? ST_IR_EX2   : ST_IR_PAUSE;
         ST_IR_EX2:   nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
         ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
         default:     nxt = ST_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_RESET;
      else         state <= nxt;
   end
endmodule

// File: rtl/dbgscan_insn.sv
module dbgscan_insn
   import dbgscan_pkg::*;
(
   input  logic              tck,
   input  logic              trst_n,
   input  tap_state_e        state,
   input  logic              tdi,
   output logic [INSN_W-1:0] insn,
   output logic              insn_lsb,
   output dr_pick_e          pick
);
   logic [INSN_W-1:0] stage;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         stage <= '0;
         insn  <= INSN_IDENT;
      end else begin
         case (state)
            ST_RESET:    insn  <= INSN_IDENT;
            ST_IR_CAP:   stage <= INSN_CAPTURED;
            ST_IR_SHIFT: stage <= {tdi, stage[INSN_W-1:1]};
            ST_IR_UPD:   insn  <= stage;
            default: ;
         endcase
      end
   end

   assign insn_lsb = stage[0];

   always_comb begin
      case (insn)
         INSN_IDENT: pick = PICK_IDENT;
         INSN_DPORT: pick = PICK_DPORT;
         INSN_APORT: pick = PICK_APORT;
         INSN_ABORT: pick = PICK_ABORT;
         default:    pick = PICK_BYPASS;
      endcase
   end
endmodule

// File: rtl/dbgscan_chain.sv
module dbgscan_chain
   import dbgscan_pkg::*;
#(
   parameter int unsigned     DATA_W     = 32,
   parameter int unsigned     ADDR_W     = 2,
   parameter logic [31:0]     ID_VALUE   = 32'h3BA0_0477,
   parameter bit              ABORT_LONG = 1'b1
)(
   input  logic              tck,
   input  logic              trst_n,
   input  tap_state_e        state,
   input  dr_pick_e          pick,
   input  logic              tdi,
   output logic              chain_lsb,
   output logic              acc_valid,
   output logic              acc_ap,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              acc_rnw,
   output logic [DATA_W-1:0] acc_wdata,
   input  logic              acc_done,
   input  logic [DATA_W-1:0] acc_rdata,
   output logic              dp_abort
);
   localparam int unsigned ACK_W  = ADDR_W + 1;
   localparam int unsigned SCAN_W = DATA_W + ACK_W;
   localparam int unsigned IDX_W  = $clog2(SCAN_W);
   localparam logic [ACK_W-1:0] ACK_WAIT = ACK_W'(1);
   localparam logic [ACK_W-1:0] ACK_OK   = ACK_W'(2);

   logic [SCAN_W-1:0] chain, chain_nxt;
   logic [DATA_W-1:0] last_rd;
   logic [IDX_W-1:0]  top_idx, abort_top;
   logic              stalled, abort_flag;
   logic              is_access;

   generate
      if (ABORT_LONG) begin : g_abort_full
         assign abort_top  = IDX_W'(SCAN_W - 1);
         assign abort_flag = chain[ACK_W];
      end else begin : g_abort_short
         assign abort_top  = IDX_W'(DATA_W - 1);
         assign abort_flag = chain[0];
      end
   endgenerate

   assign is_access = (pick == PICK_DPORT) || (pick == PICK_APORT);

   always_comb begin
      case (pick)
         PICK_BYPASS: top_idx = '0;
         PICK_IDENT:  top_idx = IDX_W'(IDENT_W - 1);
         PICK_ABORT:  top_idx = abort_top;
         default:     top_idx = IDX_W'(SCAN_W - 1);
      endcase
      chain_nxt          = chain >> 1;
      chain_nxt[top_idx] = tdi;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         chain     <= '0;
         last_rd   <= '0;
         stalled   <= 1'b0;
         acc_valid <= 1'b0;
         acc_ap    <= 1'b0;
         acc_addr  <= '0;
         acc_rnw   <= 1'b0;
         acc_wdata <= '0;
         dp_abort  <= 1'b0;
      end else begin
         dp_abort <= 1'b0;
         if (acc_valid && acc_done) begin
            acc_valid <= 1'b0;
            last_rd   <= acc_rdata;
         end
         case (state)
            ST_DR_CAP: begin
               if (pick == PICK_IDENT) chain <= SCAN_W'(ID_VALUE);
               else if (is_access) begin
                  stalled <= acc_valid;
                  chain   <= acc_valid ? {{DATA_W{1'b0}}, ACK_WAIT} : {last_rd, ACK_OK};
               end else chain <= '0;
            end
            ST_DR_SHIFT: chain <= chain_nxt;
            ST_DR_UPD: begin
               if (is_access && !stalled) begin
                  acc_valid <= 1'b1;
                  acc_ap    <= (pick == PICK_APORT);
                  acc_wdata <= chain[SCAN_W-1:ACK_W];
                  acc_addr  <= chain[ADDR_W:1];
                  acc_rnw   <= chain[0];
               end else if (pick == PICK_ABORT && abort_flag) begin
                  dp_abort  <= 1'b1;
                  acc_valid <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   assign chain_lsb = chain[0];
endmodule

// File: rtl/jtag_dbg_scan.sv
module jtag_dbg_scan
   import dbgscan_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 2,
   parameter logic [31:0] ID_VALUE   = 32'h3BA0_0477,
   parameter bit          ABORT_LONG = 1'b1
)(
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tms,
   input  logic              tdi,
   output logic              tdo,
   output logic              tdo_en,
   output logic              acc_valid,
   output logic              acc_ap,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              acc_rnw,
   output logic [DATA_W-1:0] acc_wdata,
   input  logic              acc_done,
   input  logic [DATA_W-1:0] acc_rdata,
   output logic              dp_abort
);
   initial begin
      if (DATA_W < IDENT_W) $fatal(1, "DATA_W must hold the identification word");
      if (ADDR_W < 2)       $fatal(1, "ADDR_W must leave room for a 3-bit acknowledge");
   end

   tap_state_e        state;
   dr_pick_e          pick;
   logic [INSN_W-1:0] insn_q;
   logic              insn_lsb, chain_lsb;

   dbgscan_tap u_tap (.tck, .trst_n, .tms, .state);

   dbgscan_insn u_insn (.tck, .trst_n, .state, .tdi,
                        .insn(insn_q), .insn_lsb, .pick);

   dbgscan_chain #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE),
                   .ABORT_LONG(ABORT_LONG)) u_chain (
      .tck, .trst_n, .state, .pick, .tdi, .chain_lsb,
      .acc_valid, .acc_ap, .acc_addr, .acc_rnw, .acc_wdata,
      .acc_done, .acc_rdata, .dp_abort);

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         case (state)
            ST_IR_SHIFT: begin tdo <= insn_lsb;  tdo_en <= 1'b1; end
            ST_DR_SHIFT: begin tdo <= chain_lsb; tdo_en <= 1'b1; end
            default:     begin tdo <= 1'b0;      tdo_en <= 1'b0; end
         endcase
      end
   end
endmodule

// File: rtl/dbgscan_chk.sv
module dbgscan_chk
   import dbgscan_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 2
)(
   input logic              tck,
   input logic              trst_n,
   input logic              tdo_en,
   input logic              acc_valid,
   input logic              acc_done,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [DATA_W-1:0] acc_wdata,
   input logic              dp_abort,
   input tap_state_e        state,
   input logic [INSN_W-1:0] insn_q
);
   // R3: the enable seen at a rising edge was set from a shift state
   a_r3_en_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en |-> (state == ST_DR_SHIFT || state == ST_IR_SHIFT));

   // R1: leaving Test-Logic-Reset always leaves the identification instruction
   a_r1_reset_picks_ident: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_RESET) |=> (insn_q == INSN_IDENT));

   // R6: a request appears only as the result of Update-DR
   a_r6_issue_on_update: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(acc_valid) |-> ($past(state) == ST_DR_UPD));

   // R8: an unanswered request keeps its fields unless aborted
   a_r8_request_held: assert property (@(posedge tck) disable iff (!trst_n)
      (acc_valid && !acc_done) |=>
         ((acc_valid && $stable(acc_addr) && $stable(acc_wdata)) || dp_abort));

   // R10: abort is a single-cycle pulse that leaves no request behind
   a_r10_abort_pulse: assert property (@(posedge tck) disable iff (!trst_n)
      dp_abort |-> (!acc_valid ##1 !dp_abort));
endmodule

bind jtag_dbg_scan dbgscan_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .tck, .trst_n, .tdo_en, .acc_valid, .acc_done, .acc_addr, .acc_wdata,
   .dp_abort, .state, .insn_q);

// File: tb/jtag_dbg_scan_test.sv
module jtag_dbg_scan_test;
   localparam int TCK_PERIOD = 20;
   localparam int S_RESET = 0, S_IDLE = 1, S_DSEL = 2, S_DCAP = 3, S_DSH = 4,
                  S_DEX1 = 5, S_DPAU = 6, S_DEX2 = 7, S_DUPD = 8, S_ISEL = 9,
                  S_ICAP = 10, S_ISH = 11, S_IEX1 = 12, S_IPAU = 13, S_IEX2 = 14,
                  S_IUPD = 15;

   logic tck = 1'b0, trst_n, tms, tdi, tdo, tdo_en;
   logic acc_valid, acc_ap, acc_rnw, acc_done, dp_abort;
   logic [1:0]  acc_addr;
   logic [31:0] acc_wdata, acc_rdata;

   jtag_dbg_scan uut (.tck, .trst_n, .tms, .tdi, .tdo, .tdo_en, .acc_valid,
      .acc_ap, .acc_addr, .acc_rnw, .acc_wdata, .acc_done, .acc_rdata, .dp_abort);

   always #(TCK_PERIOD/2) tck = ~tck;

   int vectors = 0, miscompares = 0, abort_seen = 0;
   bit finished = 0;

   // behavioural reference state
   int          m_state;
   logic [3:0]  m_insn, m_insn_in;
   logic [34:0] m_in;
   bit          m_busy, m_stall, m_abort;
   logic        last_o;

   task automatic vchk(input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int nxt(input int s, input logic m);
      case (s)
         S_RESET: return m ? S_RESET : S_IDLE;
         S_IDLE:  return m ? S_DSEL : S_IDLE;
         S_DSEL:  return m ? S_ISEL : S_DCAP;
         S_DCAP, S_DSH: return m ? S_DEX1 : S_DSH;
         S_DEX1:  return m ? S_DUPD : S_DPAU;
         S_DPAU:  return m ? S_DEX2 : S_DPAU;
         S_DEX2:  return m ? S_DUPD : S_DSH;
         S_ISEL:  return m ? S_RESET : S_ICAP;
         S_ICAP, S_ISH: return m ? S_IEX1 : S_ISH;
         S_IEX1:  return m ? S_IUPD : S_IPAU;
         S_IPAU:  return m ? S_IEX2 : S_IPAU;
         S_IEX2:  return m ? S_IUPD : S_ISH;
         default: return m ? S_DSEL : S_IDLE;
      endcase
   endfunction

   function automatic bit m_access();
      return (m_insn == 4'b1010) || (m_insn == 4'b1011);
   endfunction

   task automatic model_edge(input logic m);
      bit busy_before = m_busy;
      m_abort = 0;
      if (m_busy && acc_done) m_busy = 0;
      case (m_state)
         S_RESET: m_insn = 4'b1110;
         S_DCAP:  if (m_access()) m_stall = busy_before;
         S_DUPD: begin
            if (m_access() && !m_stall) m_busy = 1;
            else if (m_insn == 4'b1000 && m_in[3]) begin m_abort = 1; m_busy = 0; end
         end
         S_IUPD:  m_insn = m_insn_in;
         default: ;
      endcase
      m_state = nxt(m_state, m);
   endtask

   task automatic step(input logic m, input logic d, output logic o);
      logic tp;
      tms = m; tdi = d;
      @(posedge tck); #2 tp = tdo;
      vchk("R3 tdo stable at rising edge", tp, last_o);
      model_edge(m);
      @(negedge tck); #2 o = tdo; last_o = o;
      vchk("R3 tdo_en", tdo_en, (m_state == S_DSH || m_state == S_ISH));
      if (!tdo_en) vchk("R3 tdo idle", tdo, 0);
      vchk("R8 acc_valid", acc_valid, m_busy);
      vchk("R10 dp_abort", dp_abort, m_abort);
      if (dp_abort) abort_seen++;
   endtask

   task automatic do_reset();
      trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; acc_done = 1'b0; acc_rdata = '0;
      #(TCK_PERIOD);
      m_state = S_RESET; m_insn = 4'b1110; m_busy = 0; m_stall = 0; m_abort = 0;
      last_o = 1'b0; m_in = '0;
      vchk("R11 acc_valid in reset", acc_valid, 0);
      vchk("R11 dp_abort in reset", dp_abort, 0);
      vchk("R11 tdo_en in reset", tdo_en, 0);
      vchk("R11 tdo in reset", tdo, 0);
      @(negedge tck); #1 trst_n = 1'b1;
   endtask

   task automatic scan_ir(input logic [3:0] v, output logic [3:0] got);
      logic o;
      step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
      got[0] = o;
      m_insn_in = v;
      for (int i = 0; i < 4; i++) begin
         step(i == 3, v[i], o);
         if (i < 3) got[i+1] = o;
      end
      step(1, 0, o); step(0, 0, o);
   endtask

   task automatic scan_dr(input logic [34:0] v, input int n, output logic [34:0] got);
      logic o;
      got = '0;
      m_in = v;
      step(1, 0, o); step(0, 0, o); step(0, 0, o);
      got[0] = o;
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, v[i], o);
         if (i < n - 1) got[i+1] = o;
      end
      step(1, 0, o); step(0, 0, o);
   endtask

   task automatic respond(input logic [31:0] d);
      logic o;
      acc_rdata = d; acc_done = 1'b1;
      step(0, 0, o);
      acc_done = 1'b0;
   endtask

   initial begin
      #(TCK_PERIOD * 100000);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [3:0]  ir_got;
      logic [34:0] got;
      logic        o;
      do_reset();
      step(0, 0, o);

      // R4 / R1: identification selected after reset
      scan_dr(35'h0, 32, got);
      vchk("R4 idcode", got[31:0], 32'h3BA0_0477);

      // R2 / R5: bypass instruction
      scan_ir(4'b1111, ir_got);
      vchk("R2 IR capture", ir_got, 4'b0001);
      scan_dr(35'hB3, 8, got);
      vchk("R5 bypass 1111", got[7:0], {8'hB3 << 1} & 8'hFF);

      // R5: unlisted code falls back to bypass
      scan_ir(4'b0101, ir_got);
      scan_dr(35'h5C, 8, got);
      vchk("R5 bypass 0101", got[7:0], {8'h5C << 1} & 8'hFF);

      // R6 / R7: debug-port write
      scan_ir(4'b1010, ir_got);
      scan_dr({32'hCAFE_0123, 2'b01, 1'b0}, 35, got);
      vchk("R7 ack ok, zero data", got, {32'h0, 3'b010});
      vchk("R6 acc_ap", acc_ap, 0);
      vchk("R6 acc_addr", acc_addr, 2'b01);
      vchk("R6 acc_rnw", acc_rnw, 0);
      vchk("R6 acc_wdata", acc_wdata, 32'hCAFE_0123);

      // R8 / R7: completion then read scan returns the data
      respond(32'h1234_5678);
      vchk("R8 cleared on done", acc_valid, 0);
      scan_dr({32'h0, 2'b11, 1'b1}, 35, got);
      vchk("R7 read data returned", got, {32'h1234_5678, 3'b010});
      vchk("R6 read flag", acc_rnw, 1);
      vchk("R6 read addr", acc_addr, 2'b11);

      // R9: busy at capture -> WAIT, new request discarded
      scan_ir(4'b1011, ir_got);
      scan_dr({32'hDEAD_BEEF, 2'b10, 1'b0}, 35, got);
      vchk("R9 wait ack", got, {32'h0, 3'b001});
      vchk("R9 old ap kept", acc_ap, 0);
      vchk("R9 old addr kept", acc_addr, 2'b11);
      vchk("R9 old wdata kept", acc_wdata, 32'h0);

      // R6: access-port request after completion
      respond(32'hA5A5_0F0F);
      scan_dr({32'h0BAD_F00D, 2'b10, 1'b0}, 35, got);
      vchk("R7 ack ok after done", got, {32'hA5A5_0F0F, 3'b010});
      vchk("R6 access port", acc_ap, 1);
      vchk("R6 ap addr", acc_addr, 2'b10);
      vchk("R6 ap wdata", acc_wdata, 32'h0BAD_F00D);

      // R10: abort scan without and with the flag
      scan_ir(4'b1000, ir_got);
      abort_seen = 0;
      scan_dr(35'h7, 35, got);
      vchk("R10 abort captures zero", got, 35'h0);
      vchk("R10 flag clear keeps request", acc_valid, 1);
      vchk("R10 no pulse", abort_seen, 0);
      scan_dr(35'h8, 35, got);
      vchk("R10 request cancelled", acc_valid, 0);
      vchk("R10 one pulse", abort_seen, 1);

      // R1: five TMS-high clocks from Shift-DR
      scan_ir(4'b1111, ir_got);
      step(1, 0, o); step(0, 0, o); step(0, 0, o);
      for (int i = 0; i < 5; i++) step(1, 0, o);
      vchk("R1 reached reset", m_state, S_RESET);
      step(0, 0, o);
      scan_dr(35'h0, 32, got);
      vchk("R1 idcode after tms reset", got[31:0], 32'h3BA0_0477);

      // R11: TRST clears an outstanding request and stored data
      scan_ir(4'b1010, ir_got);
      scan_dr({32'h1111_2222, 2'b01, 1'b0}, 35, got);
      vchk("R11 request live before trst", acc_valid, 1);
      do_reset();
      step(0, 0, o);
      scan_dr(35'h0, 32, got);
      vchk("R11 idcode after trst", got[31:0], 32'h3BA0_0477);
      scan_ir(4'b1010, ir_got);
      scan_dr({32'h0, 2'b11, 1'b1}, 35, got);
      vchk("R11 stored data cleared", got, {32'h0, 3'b010});

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule